// File: doc/BRIEF.md
# Sector Erase Accumulation Window

This block gathers the sectors chosen for a multi-sector erase and then starts the self-timed erase on its own. The command decoder gives it one strobe for each sector-erase write, together with the sector number. The first strobe comes from the final cycle of the six-write erase sequence. Each later strobe is one more sector-erase command (30h). Each accepted strobe sets one bit in a selection bitmap and restarts an inter-load window timer. The window length is derived from a 50 µs limit and the clock rate.

No further command is needed to start the erase: the window timer running out starts it. The block then visits the selected sectors from the lowest index upward. Each sector takes a fixed number of cycles, which stands in for the pre-program, verify and electrical-erase steps. At the end of each sector a completion pulse carries the sector index, so that the backing array can set that sector to all ones. Status outputs report two things to the status-read path: whether the load window is still open, and whether the erase is running.

Top module: `sea_window`

## Requirements
- R1: After reset, `window_open_o`, `busy_o` and `done_o` are low and `map_o` is all zero.
- R2: A `load_i` strobe while the block is not erasing sets bit `sec_i` of `map_o` and raises `window_open_o` from the next cycle on.
- R3: Every accepted load restarts the window. `window_open_o` stays high for exactly WIN_CYC cycles after the most recent load. A load presented in the last open cycle is still accepted.
- R4: When the window runs out with no write in its last cycle, `busy_o` rises and `window_open_o` falls in the same cycle, with no further command.
- R5: While busy, the selected sectors are handled in ascending index order, one every SEC_CYC cycles. `done_o` pulses for one cycle, in the last cycle of each sector, with `done_idx_o` giving the sector index. That sector's bit is cleared at the next edge.
- R6: The cycle after the last selected sector's pulse, `busy_o` is low and `map_o` is zero.
- R7: A non-load write (`other_wr_i` high, `load_i` low) while the window is open clears `map_o`, closes the window at the next edge, and no erase follows. A non-load write while idle has no effect.
- R8: While `busy_o` is high, `load_i` and `other_wr_i` are ignored: `map_o` and the erase order do not change.
- R9: Loading the same sector more than once selects it once, and it is erased once.
- R10: WIN_CYC equals CLK_MHZ × WIN_US clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Sector-load strobe from the command decoder |
| sec_i | input | IDX_W | Sector index carried by the load |
| other_wr_i | input | 1 | Any write that is not a sector load |
| window_open_o | output | 1 | Load window open (status bit 3 meaning) |
| busy_o | output | 1 | Erase in progress |
| map_o | output | N_SEC | Pending sector bitmap |
| done_o | output | 1 | One-cycle pulse: a sector finished erasing |
| done_idx_o | output | IDX_W | Index of the sector that finished |

## Verification
A wrong timer count moves the rising edge of `busy_o` away from exactly WIN_CYC cycles after the last load. That is visible the first time any erase starts. A faulty bitmap or index encoder shows up at the first `done_o` pulse, either as an index that is out of order or missing, or as `map_o` disagreeing with the sectors that were loaded. The walk over every non-empty sector set catches any mask-dependent fault within one erase. Cancel and ignore faults show within a cycle or two on `map_o` and `window_open_o`.

// File: rtl/sea_pkg.sv
package sea_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WIN   = 2'd1,
    ST_ERASE = 2'd2
  } sea_state_e;
endpackage

// File: rtl/sea_win_timer.sv
module sea_win_timer #(
  parameter int unsigned CYC = 2500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic expired_o
);
  localparam int unsigned CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (restart_i)       cnt_q <= CW'(CYC - 1);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/sea_dwell.sv
module sea_dwell #(
  parameter int unsigned SEC_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = $clog2(SEC_CYC + 1);
  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == CW'(SEC_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sea_lowest.sv
module sea_lowest #(
  parameter int unsigned N = 32,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic [IW-1:0] idx_o
);
  // lowest set bit wins
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/sea_window.sv
module sea_window
  import sea_pkg::*;
#(
  parameter int unsigned N_SEC   = 32,
  parameter int unsigned CLK_MHZ = 50,
  parameter int unsigned WIN_US  = 50,
  parameter int unsigned SEC_CYC = 8,
  localparam int unsigned WIN_CYC = CLK_MHZ * WIN_US,
  localparam int unsigned IDX_W   = (N_SEC > 1) ? $clog2(N_SEC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [IDX_W-1:0] sec_i,
  input  logic             other_wr_i,
  output logic             window_open_o,
  output logic             busy_o,
  output logic [N_SEC-1:0] map_o,
  output logic             done_o,
  output logic [IDX_W-1:0] done_idx_o
);
  sea_state_e       state_q;
  logic [N_SEC-1:0] map_q;
  logic             load_acc, win_exp, tick;
  logic [IDX_W-1:0] cur_idx;
  logic [N_SEC-1:0] cur_bit, sel_bit;

  assign load_acc = load_i && (state_q != ST_ERASE);
  assign cur_bit  = N_SEC'(1) << cur_idx;
  assign sel_bit  = N_SEC'(1) << sec_i;

  sea_win_timer #(.CYC(WIN_CYC)) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (load_acc),
    .expired_o (win_exp)
  );

  sea_dwell #(.SEC_CYC(SEC_CYC)) i_dwell (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state_q == ST_ERASE),
    .tick_o (tick)
  );

  sea_lowest #(.N(N_SEC)) i_lowest (
    .req_i (map_q),
    .idx_o (cur_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      map_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (load_i) begin
            map_q   <= map_q | sel_bit;
            state_q <= ST_WIN;
          end
        end
        ST_WIN: begin
          if (load_i) begin
            map_q <= map_q | sel_bit;
          end else if (other_wr_i) begin
            map_q   <= '0;
            state_q <= ST_IDLE;
          end else if (win_exp) begin
            state_q <= ST_ERASE;
          end
        end
        ST_ERASE: begin
          if (tick) begin
            map_q <= map_q & ~cur_bit;
            if ((map_q & ~cur_bit) == '0) state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign window_open_o = (state_q == ST_WIN);
  assign busy_o        = (state_q == ST_ERASE);
  assign map_o         = map_q;
  assign done_o        = tick;
  assign done_idx_o    = cur_idx;
endmodule

// File: rtl/sea_window_chk.sv
module sea_window_chk #(
  parameter int unsigned N_SEC = 32,
  localparam int unsigned IDX_W = (N_SEC > 1) ? $clog2(N_SEC) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_i,
  input logic [IDX_W-1:0] sec_i,
  input logic             other_wr_i,
  input logic             window_open_o,
  input logic             busy_o,
  input logic [N_SEC-1:0] map_o,
  input logic             done_o,
  input logic [IDX_W-1:0] done_idx_o
);
  a_r4_open_busy_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(window_open_o && busy_o));

  a_r2_load_sets_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && load_i) |=> (window_open_o && map_o[$past(sec_i)]));

  a_r5_done_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (busy_o && map_o[done_idx_o]));

  a_r5_done_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !map_o[$past(done_idx_o)]);

  a_r6_last_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $countones(map_o) == 1) |=> (!busy_o && map_o == '0));

  a_r7_cancel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (window_open_o && other_wr_i && !load_i) |=> (!window_open_o && !busy_o && map_o == '0));

  a_r8_map_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> $stable(map_o));
endmodule

bind sea_window sea_window_chk #(.N_SEC(N_SEC)) i_sea_window_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .load_i        (load_i),
  .sec_i         (sec_i),
  .other_wr_i    (other_wr_i),
  .window_open_o (window_open_o),
  .busy_o        (busy_o),
  .map_o         (map_o),
  .done_o        (done_o),
  .done_idx_o    (done_idx_o)
);

// File: tb/test_sea_window.sv
module test_sea_window;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned NS   = 8;
  localparam int unsigned MHZ  = 1;
  localparam int unsigned US   = 6;
  localparam int unsigned SC   = 3;
  localparam int unsigned W    = MHZ * US;  // R10 expected window length
  localparam int unsigned IW   = 3;

  logic          clk = 0, rst_n = 0;
  logic          load = 0, other = 0;
  logic [IW-1:0] sec = '0;
  logic          win_open, busy, done;
  logic [NS-1:0] map;
  logic [IW-1:0] done_idx;
  int tests = 0, fails = 0, cycles = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sea_window #(.N_SEC(NS), .CLK_MHZ(MHZ), .WIN_US(US), .SEC_CYC(SC)) i_sea_window (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .sec_i(sec), .other_wr_i(other),
    .window_open_o(win_open), .busy_o(busy), .map_o(map),
    .done_o(done), .done_idx_o(done_idx)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic l, input logic [IW-1:0] s, input logic o);
    load = l; sec = s; other = o;
    @(negedge clk);
    load = 0; other = 0; sec = '0;
  endtask

  function automatic int nth_set(input logic [NS-1:0] m, input int k);
    int c = 0;
    for (int i = 0; i < NS; i++) begin
      if (m[i]) begin
        if (c == k) return i;
        c++;
      end
    end
    return -1;
  endfunction

  // Called at the negedge right after the last load edge.
  task automatic finish(input logic [NS-1:0] m, input bit poke);
    int n = $countones(m);
    chk("R2 map after loads", map, m);
    for (int c = 1; c <= W; c++) begin
      chk("R3/R10 window open", win_open, 1);
      chk("R3 not busy in window", busy, 0);
      step(0, 0, 0);
    end
    chk("R4 busy after expiry", busy, 1);
    chk("R4 window closed", win_open, 0);
    for (int j = 1; j <= n * SC; j++) begin
      if (j % SC == 0) begin
        chk("R5 done pulse", done, 1);
        chk("R5 ascending index", done_idx, nth_set(m, j / SC - 1));
      end else begin
        chk("R5 no pulse", done, 0);
      end
      if (poke && (j == 2 || j == 3)) chk("R8 map frozen", map, m);
      if (poke && j == 1)      step(1, 3'd4, 0);
      else if (poke && j == 2) step(0, 0, 1);
      else                     step(0, 0, 0);
    end
    chk("R6 busy low", busy, 0);
    chk("R6 map empty", map, 0);
    chk("R6 done low", done, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++; tests++;
        $display("FAIL watchdog: got %0d expected <150000 cycles", cycles);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 window", win_open, 0);
    chk("R1 busy", busy, 0);
    chk("R1 map", map, 0);
    chk("R1 done", done, 0);
    rst_n = 1;
    @(negedge clk);

    // R7: other write while idle does nothing
    step(0, 0, 1);
    chk("R7 idle write window", win_open, 0);
    chk("R7 idle write map", map, 0);
    chk("R7 idle write busy", busy, 0);

    // R2/R5: every non-empty set, loaded highest first with gaps
    for (int m = 1; m < (1 << NS); m++) begin
      for (int i = NS - 1; i >= 0; i--) begin
        if (m[i]) begin
          if (i != nth_set(NS'(m), 0)) begin
            step(1, IW'(i), 0);
            chk("R2 window opens", win_open, 1);
            chk("R2 bit set", map[i], 1);
            step(0, 0, 0);
          end else begin
            step(1, IW'(i), 0);
          end
        end
      end
      finish(NS'(m), 0);
    end

    // R3: load in last open cycle is accepted and restarts
    step(1, 3'd1, 0);
    for (int c = 1; c < W; c++) step(0, 0, 0);
    chk("R3 last open cycle", win_open, 1);
    step(1, 3'd5, 0);
    finish(8'h22, 0);

    // R7: cancel inside the window
    step(1, 3'd3, 0);
    step(0, 0, 0);
    step(0, 0, 1);
    chk("R7 cancel window", win_open, 0);
    chk("R7 cancel map", map, 0);
    for (int c = 0; c < W + 2; c++) begin
      chk("R7 no erase", busy, 0);
      step(0, 0, 0);
    end

    // R9: duplicate loads
    step(1, 3'd2, 0);
    step(1, 3'd2, 0);
    step(1, 3'd2, 0);
    finish(8'h04, 0);

    // R8: writes during erase ignored
    step(1, 3'd7, 0);
    step(1, 3'd0, 0);
    finish(8'h81, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule